// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the clocked command interpreter of a parallel NOR flash, seen from the device side. The host issues write strokes. Each stroke is a one-cycle strobe that carries a word address and a data word. The block tracks the unlock prefixes that guard every destructive command and decodes the final opcode and its target address. It then starts a program or erase on an internal countdown timer, which stands in for the real array timing. The active operation type and its busy state are reported on the outputs.

The boot block is protected by an active-low write-protect input. While any program or erase runs, strokes are dropped. There is one exception: a sector or block erase may be suspended with a single stroke and later resumed. While an erase is suspended, word programs are allowed anywhere outside the region that is being erased. An asynchronous reset returns the block to read mode and discards any partial sequence.

Top module: `flash_cmd_decoder`

## Requirements
- R1: With rst_ni low, busy_o=0, op_o=0 and susp_o=0 at once. A partly entered unlock sequence is discarded, so its remaining strokes entered after reset start nothing.
- R2: The strokes AAh@555h, 55h@2AAh and A0h@555h, followed by a fourth stroke at any address, start a word program. From the cycle after the fourth stroke, op_o=1 and busy_o=1 for PROG_CYC cycles, and op_addr_o/op_data_o hold the fourth stroke's address and data. Unlock addresses are compared on addr_i[10:0] and opcodes on data_i[7:0].
- R3: The strokes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and then 50h start a sector erase of the sector selected by addr_i[20:11]. op_o=2 and busy_o=1 for ERASE_CYC cycles.
- R4: The same six-stroke sequence ending in 30h starts a block erase of the block selected by addr_i[20:15]. op_o=3 for ERASE_CYC cycles.
- R5: The same sequence ending in 10h with addr_i[10:0]=555h starts a chip erase: op_o=4 for CHIP_CYC cycles. If the final address differs, nothing starts.
- R6: A stroke that does not match the expected step sends the tracker back to idle, and no operation starts from the strokes that follow it.
- R7: While a program or erase runs, strokes are ignored, including complete command sequences. No operation starts after the running one ends.
- R8: With wp_ni low, a program, sector erase or block erase whose addr_i[20:15] equals BOOT_BLK is ignored, and chip erase is ignored at any address. Targets outside the boot block still run.
- R9: A stroke of B0h at any address during a sector or block erase keeps busy_o high for SUSP_CYC cycles. After that, busy_o=0 and susp_o=1. B0h during a chip erase is ignored.
- R10: While an erase is suspended, a word program outside the suspended sector or block runs for PROG_CYC cycles and then returns to the suspended state. A program inside that region is ignored, and so are erase commands.
- R11: A stroke of 30h at any address while suspended, with no sequence in progress, resumes the erase. The erase then runs only its remaining cycles, so that cycles before and after the suspend add up to the full erase time. A 30h stroke in read mode does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write stroke strobe, one cycle per stroke |
| addr_i | input | AW (21) | Stroke word address |
| data_i | input | DW (16) | Stroke data |
| wp_ni | input | 1 | Boot block write protect, active low |
| busy_o | output | 1 | Internal operation or suspend latency running |
| op_o | output | 3 | Active operation: 0 none, 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| susp_o | output | 1 | An erase is suspended |
| op_addr_o | output | AW (21) | Target address of the last accepted operation |
| op_data_o | output | DW (16) | Data of the last accepted program |

## Verification
The assertions assume that strokes are one-cycle pulses with stable address and data in that cycle. They also assume that wp_ni does not change during a command sequence, so that the protection decision is taken on a settled level. The bench drives every input at the falling clock edge and holds wp_ni constant from before the first stroke of a sequence until the operation's result has been checked. It issues strokes back to back or with known idle gaps, so that the busy windows it measures follow exact cycle counts.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int KEY_AW = 11;

  localparam logic [7:0]        KEY_A      = 8'hAA;
  localparam logic [7:0]        KEY_B      = 8'h55;
  localparam logic [7:0]        OPC_PROG   = 8'hA0;
  localparam logic [7:0]        OPC_ERS    = 8'h80;
  localparam logic [7:0]        OPC_SECT   = 8'h50;
  localparam logic [7:0]        OPC_BLK    = 8'h30;
  localparam logic [7:0]        OPC_CHIP   = 8'h10;
  localparam logic [7:0]        OPC_SUSP   = 8'hB0;
  localparam logic [7:0]        OPC_RESUME = 8'h30;
  localparam logic [KEY_AW-1:0] ADR_KEY_A  = 11'h555;
  localparam logic [KEY_AW-1:0] ADR_KEY_B  = 11'h2AA;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_BLK  = 3'd3,
    OP_CHIP = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUSP_WAIT,
    ST_SUSP,
    ST_SUSP_PROG
  } ctl_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_U1,
    SQ_U2,
    SQ_PDATA,
    SQ_E1,
    SQ_E2,
    SQ_E3
  } seq_e;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic [KEY_AW-1:0] key_addr_i,
  input  logic [7:0]        opc_i,
  output logic              idle_o,
  output logic              cmd_vld_o,
  output op_e               cmd_op_o
);

  seq_e st_q, st_d;
  logic at_a, at_b;

  assign at_a = (key_addr_i == ADR_KEY_A);
  assign at_b = (key_addr_i == ADR_KEY_B);

  always_comb begin
    st_d      = st_q;
    cmd_vld_o = 1'b0;
    cmd_op_o  = OP_NONE;
    if (!en_i) begin
      st_d = SQ_IDLE;
    end else if (wr_i) begin
      unique case (st_q)
        SQ_IDLE: st_d = (at_a && opc_i == KEY_A) ? SQ_U1 : SQ_IDLE;
        SQ_U1:   st_d = (at_b && opc_i == KEY_B) ? SQ_U2 : SQ_IDLE;
        SQ_U2: begin
          if (at_a && opc_i == OPC_PROG)     st_d = SQ_PDATA;
          else if (at_a && opc_i == OPC_ERS) st_d = SQ_E1;
          else                               st_d = SQ_IDLE;
        end
        SQ_PDATA: begin
          st_d      = SQ_IDLE;
          cmd_vld_o = 1'b1;
          cmd_op_o  = OP_PROG;
        end
        SQ_E1: st_d = (at_a && opc_i == KEY_A) ? SQ_E2 : SQ_IDLE;
        SQ_E2: st_d = (at_b && opc_i == KEY_B) ? SQ_E3 : SQ_IDLE;
        SQ_E3: begin
          st_d = SQ_IDLE;
          if (opc_i == OPC_SECT) begin
            cmd_vld_o = 1'b1;
            cmd_op_o  = OP_SECT;
          end else if (opc_i == OPC_BLK) begin
            cmd_vld_o = 1'b1;
            cmd_op_o  = OP_BLK;
          end else if (opc_i == OPC_CHIP && at_a) begin
            cmd_vld_o = 1'b1;
            cmd_op_o  = OP_CHIP;
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else         st_q <= st_d;
  end

  assign idle_o = (st_q == SQ_IDLE);

  AST_CMD_RETURNS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |=> idle_o); // R6

endmodule

// File: rtl/fcd_timer.sv
module fcd_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          hold_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= val_i;
    else if (!hold_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // final counting cycle of the loaded interval
  assign last_o = !hold_i && (cnt_q == CW'(1));

  AST_TIMER_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0); // R2

  AST_HOLD_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !load_i) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import fcd_pkg::*;
#(
  parameter int SW       = 10,
  parameter int BW       = 6,
  parameter int BOOT_BLK = 0
) (
  input  logic          wp_ni,
  input  op_e           cmd_op_i,
  input  logic [SW-1:0] cmd_sec_i,
  input  logic          susp_i,
  input  op_e           era_op_i,
  input  logic [SW-1:0] era_sec_i,
  output logic          prot_o,
  output logic          region_o
);

  logic in_boot, same_sec, same_blk;

  assign in_boot  = (cmd_sec_i[SW-1 -: BW] == BW'(BOOT_BLK));
  assign same_sec = (cmd_sec_i == era_sec_i);
  assign same_blk = (cmd_sec_i[SW-1 -: BW] == era_sec_i[SW-1 -: BW]);

  always_comb begin
    prot_o = 1'b0;
    if (!wp_ni) begin
      unique case (cmd_op_i)
        OP_CHIP:                  prot_o = 1'b1;
        OP_PROG, OP_SECT, OP_BLK: prot_o = in_boot;
        default:                  prot_o = 1'b0;
      endcase
    end
  end

  assign region_o = susp_i && ((era_op_i == OP_SECT) ? same_sec : same_blk);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW        = 21,
  parameter int DW        = 16,
  parameter int SECT_LSB  = 11,
  parameter int BLK_LSB   = 15,
  parameter int BOOT_BLK  = 0,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64,
  parameter int CHIP_CYC  = 200,
  parameter int SUSP_CYC  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          wp_ni,
  output logic          busy_o,
  output logic [2:0]    op_o,
  output logic          susp_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o
);

  localparam int SW   = AW - SECT_LSB;
  localparam int BW   = AW - BLK_LSB;
  localparam int M1   = (PROG_CYC > SUSP_CYC) ? PROG_CYC : SUSP_CYC;
  localparam int M2   = (ERASE_CYC > CHIP_CYC) ? ERASE_CYC : CHIP_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  ctl_e          state_q, state_d;
  op_e           era_op_q, cmd_op, op_cur;
  logic [SW-1:0] era_sec_q;
  logic [AW-1:0] op_addr_q;
  logic [DW-1:0] op_data_q;

  logic          seq_idle, seq_en, cmd_vld;
  logic          prot_hit, region_hit, accept;
  logic          resume_hit, susp_hit;
  logic          aux_load, ers_load, aux_last, ers_last;
  logic [CW-1:0] aux_val, ers_val;
  logic          start_prog, start_ers;
  logic [7:0]    opc;

  assign opc = data_i[7:0];

  assign resume_hit = (state_q == ST_SUSP) && wr_i && seq_idle && (opc == OPC_RESUME);
  assign susp_hit   = (state_q == ST_ERASE) && wr_i && (opc == OPC_SUSP) &&
                      (era_op_q != OP_CHIP);
  assign seq_en     = ((state_q == ST_IDLE) || (state_q == ST_SUSP)) && !resume_hit;

  fcd_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .en_i       (seq_en),
    .key_addr_i (addr_i[KEY_AW-1:0]),
    .opc_i      (opc),
    .idle_o     (seq_idle),
    .cmd_vld_o  (cmd_vld),
    .cmd_op_o   (cmd_op)
  );

  fcd_guard #(
    .SW       (SW),
    .BW       (BW),
    .BOOT_BLK (BOOT_BLK)
  ) u_guard (
    .wp_ni     (wp_ni),
    .cmd_op_i  (cmd_op),
    .cmd_sec_i (addr_i[AW-1:SECT_LSB]),
    .susp_i    (state_q == ST_SUSP),
    .era_op_i  (era_op_q),
    .era_sec_i (era_sec_q),
    .prot_o    (prot_hit),
    .region_o  (region_hit)
  );

  // program and suspend latency share one counter, erase keeps its own
  fcd_timer #(.CW(CW)) u_aux_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (aux_load),
    .val_i  (aux_val),
    .hold_i (1'b0),
    .last_o (aux_last)
  );

  fcd_timer #(.CW(CW)) u_ers_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ers_load),
    .val_i  (ers_val),
    .hold_i (state_q != ST_ERASE),
    .last_o (ers_last)
  );

  assign accept = cmd_vld && !prot_hit;

  always_comb begin
    state_d    = state_q;
    aux_load   = 1'b0;
    aux_val    = CW'(PROG_CYC);
    ers_load   = 1'b0;
    ers_val    = (cmd_op == OP_CHIP) ? CW'(CHIP_CYC) : CW'(ERASE_CYC);
    start_prog = 1'b0;
    start_ers  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cmd_op == OP_PROG) begin
            start_prog = 1'b1;
            aux_load   = 1'b1;
            state_d    = ST_PROG;
          end else begin
            start_ers = 1'b1;
            ers_load  = 1'b1;
            state_d   = ST_ERASE;
          end
        end
      end
      ST_PROG: if (aux_last) state_d = ST_IDLE;
      ST_ERASE: begin
        if (ers_last) begin
          state_d = ST_IDLE;
        end else if (susp_hit) begin
          aux_load = 1'b1;
          aux_val  = CW'(SUSP_CYC);
          state_d  = ST_SUSP_WAIT;
        end
      end
      ST_SUSP_WAIT: if (aux_last) state_d = ST_SUSP;
      ST_SUSP: begin
        if (resume_hit) begin
          state_d = ST_ERASE;
        end else if (accept && cmd_op == OP_PROG && !region_hit) begin
          start_prog = 1'b1;
          aux_load   = 1'b1;
          state_d    = ST_SUSP_PROG;
        end
      end
      ST_SUSP_PROG: if (aux_last) state_d = ST_SUSP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      era_op_q  <= OP_NONE;
      era_sec_q <= '0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_prog) begin
        op_addr_q <= addr_i;
        op_data_q <= data_i;
      end
      if (start_ers) begin
        era_op_q  <= cmd_op;
        era_sec_q <= addr_i[AW-1:SECT_LSB];
        op_addr_q <= addr_i;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PROG, ST_SUSP_PROG:  op_cur = OP_PROG;
      ST_ERASE, ST_SUSP_WAIT: op_cur = era_op_q;
      default:                op_cur = OP_NONE;
    endcase
  end

  assign busy_o    = (state_q == ST_PROG) || (state_q == ST_ERASE) ||
                     (state_q == ST_SUSP_WAIT) || (state_q == ST_SUSP_PROG);
  assign op_o      = op_cur;
  assign susp_o    = (state_q == ST_SUSP) || (state_q == ST_SUSP_PROG);
  assign op_addr_o = op_addr_q;
  assign op_data_o = op_data_q;

  AST_NO_CMD_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_vld); // R7

  AST_CHIP_WP_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld && cmd_op == OP_CHIP && !wp_ni) |=> op_o != 3'(OP_CHIP)); // R8

  AST_SUSP_PROG_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP_PROG) |->
      ((era_op_q == OP_SECT) ? (op_addr_q[AW-1:SECT_LSB] != era_sec_q)
                             : (op_addr_q[AW-1:BLK_LSB] != era_sec_q[SW-1 -: BW]))); // R10

  AST_BUSY_HAS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> op_o != 3'(OP_NONE)); // R2

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int NV = 12;
  localparam logic [DW-1:0] PDATA = 16'hC3A5;

  // {kind[3], addr[21], wp_n[1], exp_op[3], exp_cyc[8]}; kind 0 prog,1 sect,2 blk,3 chip,4 broken
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 21'h12345, 1'b1, 3'd1, 8'd4},
    {3'd1, 21'h0A800, 1'b1, 3'd2, 8'd10},
    {3'd2, 21'h18000, 1'b1, 3'd3, 8'd10},
    {3'd3, 21'h00555, 1'b1, 3'd4, 8'd12},
    {3'd0, 21'h00100, 1'b0, 3'd0, 8'd0},
    {3'd1, 21'h00800, 1'b0, 3'd0, 8'd0},
    {3'd2, 21'h00000, 1'b0, 3'd0, 8'd0},
    {3'd3, 21'h00555, 1'b0, 3'd0, 8'd0},
    {3'd1, 21'h08800, 1'b0, 3'd2, 8'd10},
    {3'd4, 21'h04000, 1'b1, 3'd0, 8'd0},
    {3'd3, 21'h00556, 1'b1, 3'd0, 8'd0},
    {3'd0, 21'h1F000, 1'b0, 3'd1, 8'd4}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic          wp_ni = 1'b1;
  logic          busy_o, susp_o;
  logic [2:0]    op_o;
  logic [AW-1:0] op_addr_o;
  logic [DW-1:0] op_data_o;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(
    .AW(AW), .DW(DW), .BOOT_BLK(0),
    .PROG_CYC(4), .ERASE_CYC(10), .CHIP_CYC(12), .SUSP_CYC(3)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
    .wp_ni(wp_ni), .busy_o(busy_o), .op_o(op_o), .susp_o(susp_o),
    .op_addr_o(op_addr_o), .op_data_o(op_data_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic stroke(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_seq(int kind, logic [AW-1:0] a);
    if (kind == 4) begin
      stroke(21'h555, 16'hAA);
      stroke(21'h123, 16'h55);
      stroke(21'h555, 16'hA0);
      stroke(a, PDATA);
    end else begin
      stroke(21'h555, 16'hAA);
      stroke(21'h2AA, 16'h55);
      if (kind == 0) begin
        stroke(21'h555, 16'hA0);
        stroke(a, PDATA);
      end else begin
        stroke(21'h555, 16'h80);
        stroke(21'h555, 16'hAA);
        stroke(21'h2AA, 16'h55);
        stroke(a, (kind == 1) ? 16'h50 : (kind == 2) ? 16'h30 : 16'h10);
      end
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic string tag_of(int kind, logic wp);
    if (!wp && kind != 4) return (kind == 0 || kind == 3) ? "R8" : "R8 erase";
    case (kind)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    int n;
    idle(3);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 op in reset", op_o, 0);
    chk("R1 susp in reset", susp_o, 0);
    rst_ni = 1'b1;
    idle(2);

    for (int v = 0; v < NV; v++) begin
      int kind;
      logic [AW-1:0] a;
      int eop, ecyc;
      string tg;
      kind = int'(VEC[v][35:33]);
      a    = VEC[v][32:12];
      eop  = int'(VEC[v][10:8]);
      ecyc = int'(VEC[v][7:0]);
      wp_ni = VEC[v][11];
      tg = tag_of(kind, wp_ni);
      idle(1);
      run_seq(kind, a);
      chk(tg, op_o, eop);
      chk(tg, busy_o, (eop != 0) ? 1 : 0);
      if (eop != 0) begin
        chk(tg, int'(op_addr_o), int'(a));
        if (kind == 0) chk("R2 data", op_data_o, PDATA);
        wait_idle(n);
        chk(tg, n, ecyc);
      end else begin
        idle(2);
        chk(tg, busy_o, 0);
      end
      wp_ni = 1'b1;
      idle(1);
    end

    // R7: full program sequence inside a sector erase
    run_seq(1, 21'h0A800);
    run_seq(0, 21'h30000);
    chk("R7 op kept", op_o, 2);
    wait_idle(n);
    chk("R7 erase length", n, 6);
    idle(2);
    chk("R7 nothing after", busy_o, 0);
    chk("R7 op none", op_o, 0);

    // R9 suspend, R10 program during suspend, R11 resume
    run_seq(2, 21'h18000);
    idle(2);
    stroke(21'h1ABCD, 16'h00B0);
    chk("R9 still busy", busy_o, 1);
    chk("R9 op kept", op_o, 3);
    wait_idle(n);
    chk("R9 suspend latency", n, 3);
    chk("R9 suspended", susp_o, 1);
    run_seq(0, 21'h18010);
    chk("R10 inside region", busy_o, 0);
    run_seq(0, 21'h20000);
    chk("R10 outside op", op_o, 1);
    wait_idle(n);
    chk("R10 prog length", n, 4);
    chk("R10 back to suspend", susp_o, 1);
    run_seq(1, 21'h28000);
    chk("R10 erase dropped", busy_o, 0);
    idle(1);
    stroke(21'h00123, 16'h0030);
    chk("R11 resumed op", op_o, 3);
    chk("R11 susp clear", susp_o, 0);
    wait_idle(n);
    chk("R11 remaining cycles", n, 7);
    idle(1);

    // R9: suspend ignored on chip erase
    run_seq(3, 21'h00555);
    stroke(21'h00000, 16'h00B0);
    chk("R9 chip op kept", op_o, 4);
    wait_idle(n);
    chk("R9 chip full length", n, 11);
    chk("R9 chip no suspend", susp_o, 0);

    // R11: resume in read mode does nothing
    stroke(21'h00000, 16'h0030);
    chk("R11 resume idle", busy_o, 0);
    idle(1);

    // R1: reset mid operation and mid sequence
    run_seq(1, 21'h0A800);
    chk("R1 pre-reset busy", busy_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R1 async busy", busy_o, 0);
    chk("R1 async op", op_o, 0);
    idle(1);
    rst_ni = 1'b1;
    idle(1);
    stroke(21'h555, 16'hAA);
    rst_ni = 1'b0;
    idle(1);
    rst_ni = 1'b1;
    idle(1);
    stroke(21'h2AA, 16'h55);
    stroke(21'h555, 16'hA0);
    stroke(21'h04444, PDATA);
    chk("R1 partial discarded", busy_o, 0);

    report();
    $finish;
  end

endmodule